// File: doc/BRIEF.md
# USB device packet response controller

This block is the device-side decision stage that runs once per received USB packet. After a packet receiver hands over the PID byte, the next two bytes and the total byte count, the controller checks the device address, remembers which token (SETUP, OUT or IN) is in progress, and picks the reply. The reply is one of four things: an ACK, a NAK, a handshake byte that the consumer left in an endpoint status slot, or a request to transmit one of the IN endpoint buffers. Line coding, bit stuffing and CRC are handled elsewhere. The block only decides what to send and drives a transmit request that stays asserted until the transmitter reports completion.

Received data lives in two buffer halves. An accepted DATA packet latches its length and the token it belongs to, and flips the half that the receiver fills next, so the consumer reads a stable half while the other half takes the next packet. The consumer releases the data with a one-cycle `rx_done` strobe. The block also holds the active device address. It takes a new address from the consumer only when a data packet has finished transmitting, so the status stage of an address change still completes under the old address.

Top module: `usb_reply_ctrl`

## Requirements
- R1: While reset is held, `tx_req`, `ep_nak_wr`, `rx_len`, `rx_half` and `dev_addr` are all 0, and no token is recorded.
- R2: For a non-DATA packet of 3 or more bytes, if bits 6:0 of the second byte differ from `dev_addr`, the recorded token is cleared and no reply is sent. The same applies to a matching packet whose PID is not IN, SETUP or OUT. A cleared token makes the next DATA packet ignored.
- R3: A matching SETUP (0x2D) or OUT (0xE1) token records its PID as the current token and sends no reply. When `EN_OUT1` is set and bit 7 of the second byte is 1, an OUT records the marker 0xFF instead.
- R4: A DATA0 (0xC3) or DATA1 (0x4B) packet is ignored, with no reply and no state change, when no token is recorded. It gets a NAK (0x5A) when `rx_len` is nonzero.
- R5: A DATA packet of exactly 3 bytes (PID plus CRC) with a token recorded and `rx_len` zero gets an ACK (0xD2) and leaves `rx_len`, `rx_tok` and `rx_half` unchanged.
- R6: A DATA packet of 4 or more bytes with a token recorded and `rx_len` zero gets an ACK. It sets `rx_len` to the packet byte count and `rx_tok` to the recorded token, and toggles `rx_half`.
- R7: A matching IN (0x69) token gets a NAK while `rx_len` is nonzero.
- R8: Otherwise, if bit 4 of the selected endpoint's status byte is 1, that byte is sent unchanged as a handshake PID (`tx_data`=0) and `ep_nak_wr` stays 0.
- R9: If that bit is 0, a data transmit is requested (`tx_data`=1) from the selected endpoint's buffer. `ep_nak_wr` pulses for exactly the first request cycle, so the consumer sets that status back to NAK.
- R10: Endpoint select on `tx_ep`: bit 7 of the second byte equal to 0 gives 0. Otherwise it gives 2 when `EN_EP3` is set and bit 0 of the third byte is 1, and 1 in every other case.
- R11: `dev_addr` takes the value of `new_addr` only in the cycle in which `tx_done` ends a data transmit, never after a handshake.
- R12: `tx_req` rises exactly two clock cycles after the `pkt_valid` cycle of a packet that needs a reply. It stays high until the cycle in which `tx_done` is seen, and is low in the following cycle.
- R13: Any packet shorter than 3 bytes is ignored: no reply and no change to the token or the receive state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe: a packet has ended, fields valid |
| pkt_len | input | LEN_W | Packet byte count including PID and CRC |
| pkt_pid | input | 8 | First byte (PID) |
| pkt_b1 | input | 8 | Second byte (address, endpoint low bit in bit 7) |
| pkt_b2 | input | 8 | Third byte (bit 0 picks the third endpoint) |
| ep_status | input | NUM_EP*8 | Status byte per IN endpoint, endpoint 0 in the low byte |
| rx_done | input | 1 | Consumer has taken the received data |
| new_addr | input | 7 | Address to adopt after the next data transmit |
| tx_done | input | 1 | Transmitter finished the requested packet |
| tx_req | output | 1 | Reply requested, held until `tx_done` |
| tx_data | output | 1 | 1: send endpoint buffer, 0: send handshake `tx_pid` |
| tx_pid | output | 8 | Handshake PID to send |
| tx_ep | output | 2 | Endpoint buffer to send |
| ep_nak_wr | output | 1 | Pulse: set status of `tx_ep` back to NAK |
| rx_len | output | LEN_W | Byte count of unconsumed received data, 0 if free |
| rx_tok | output | 8 | Token the received data belongs to |
| rx_half | output | 1 | Buffer half holding the latest received data |
| dev_addr | output | 7 | Active device address |

## Verification
A stale recorded token shows up on the very next DATA packet: the packet is answered when it should be ignored, or the other way round, and `tx_req` is wrong two cycles after `pkt_valid`. A wrong `rx_len` turns the next IN or DATA reply from NAK into data or ACK. A wrong `rx_half` appears at the ports as soon as the next store happens. An address applied too early makes the next token addressed to the old address go unanswered. The bench therefore follows each packet with the packets that expose the state it left behind, using random traffic mixed with directed sequences around consumption and address changes.

// File: rtl/usb_reply_pkg.sv
// Package: shared PID codes, state and decision types for the reply controller.
// Assumes full 8-bit PID bytes (type nibble plus its complement).
package usb_reply_pkg;
    localparam logic [7:0] PID_OUT   = 8'hE1;
    localparam logic [7:0] PID_IN    = 8'h69;
    localparam logic [7:0] PID_SETUP = 8'h2D;
    localparam logic [7:0] PID_DATA0 = 8'hC3;
    localparam logic [7:0] PID_DATA1 = 8'h4B;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;
    localparam logic [7:0] TOK_NONE  = 8'h00;
    localparam logic [7:0] TOK_OUT1  = 8'hFF;
    localparam int         EP_W      = 2;

    typedef enum logic [1:0] {
        ST_IDLE, ST_DECODE, ST_REPLY_REQ, ST_WAIT_TX_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        ACT_NONE, ACT_HS, ACT_DATA
    } reply_act_t;

    typedef struct packed {
        reply_act_t       act;
        logic [7:0]       pid;
        logic [EP_W-1:0]  ep;
        logic             tok_wr;
        logic [7:0]       tok_val;
        logic             store;
    } decision_t;
endpackage

// File: rtl/usb_reply_decode.sv
// Module: combinational reply decision for one captured packet.
// Assumes the captured fields and the consumer status stay stable during DECODE.
module usb_reply_decode
    import usb_reply_pkg::*;
#(
    parameter int LEN_W   = 5,
    parameter bit EN_OUT1 = 1'b1,
    parameter bit EN_EP3  = 1'b1,
    localparam int NUM_EP = EN_EP3 ? 3 : 2
) (
    input  logic [7:0]          pid,
    input  logic [LEN_W-1:0]    len,
    input  logic [7:0]          b1,
    input  logic [7:0]          b2,
    input  logic [7:0]          cur_tok,
    input  logic [LEN_W-1:0]    rx_len,
    input  logic [6:0]          dev_addr,
    input  logic [NUM_EP*8-1:0] ep_status,
    output decision_t           dec
);
    logic [EP_W-1:0] ep_sel;
    logic [7:0]      ep_st;
    logic            is_data;

    // Pick the IN endpoint from the endpoint bit and the optional third-byte select
    always_comb begin
        if (!b1[7])                ep_sel = 2'd0;
        else if (EN_EP3 && b2[0])  ep_sel = 2'd2;
        else                       ep_sel = 2'd1;
    end

    // Fetch the selected endpoint's status byte
    always_comb begin
        ep_st = 8'h00;
        for (int i = 0; i < NUM_EP; i++)
            if (ep_sel == EP_W'(i)) ep_st = ep_status[i*8 +: 8];
    end

    assign is_data = (pid == PID_DATA0) || (pid == PID_DATA1);

    // Decide reply, token update and storage for the captured packet
    always_comb begin
        dec     = '0;
        dec.act = ACT_NONE;
        dec.ep  = ep_sel;
        if (len < LEN_W'(3)) begin
            dec.act = ACT_NONE;
        end else if (is_data) begin
            if (cur_tok == TOK_NONE) begin
                dec.act = ACT_NONE;
            end else if (rx_len != '0) begin
                dec.act = ACT_HS;
                dec.pid = PID_NAK;
            end else begin
                dec.act   = ACT_HS;
                dec.pid   = PID_ACK;
                dec.store = (len >= LEN_W'(4));
            end
        end else if (b1[6:0] != dev_addr) begin
            dec.tok_wr  = 1'b1;
            dec.tok_val = TOK_NONE;
        end else if (pid == PID_IN) begin
            if (rx_len != '0) begin
                dec.act = ACT_HS;
                dec.pid = PID_NAK;
            end else if (ep_st[4]) begin
                dec.act = ACT_HS;
                dec.pid = ep_st;
            end else begin
                dec.act = ACT_DATA;
            end
        end else if (pid == PID_SETUP) begin
            dec.tok_wr  = 1'b1;
            dec.tok_val = PID_SETUP;
        end else if (pid == PID_OUT) begin
            dec.tok_wr  = 1'b1;
            dec.tok_val = (EN_OUT1 && b1[7]) ? TOK_OUT1 : PID_OUT;
        end else begin
            dec.tok_wr  = 1'b1;
            dec.tok_val = TOK_NONE;
        end
    end
endmodule

// File: rtl/usb_reply_rxbuf.sv
// Module: receive length/token latch and buffer-half selection.
// Assumes store is only raised when the stored length is zero.
module usb_reply_rxbuf #(
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store,
    input  logic [LEN_W-1:0] len_in,
    input  logic [7:0]       tok_in,
    input  logic             consume,
    output logic [LEN_W-1:0] rx_len,
    output logic [7:0]       rx_tok,
    output logic             rx_half
);
    // Latch accepted data, flip halves, and free on consumer release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_len  <= '0;
            rx_tok  <= 8'h00;
            rx_half <= 1'b0;
        end else if (store) begin
            rx_len  <= len_in;
            rx_tok  <= tok_in;
            rx_half <= ~rx_half;
        end else if (consume) begin
            rx_len  <= '0;
        end
    end
endmodule

// File: rtl/usb_reply_addr.sv
// Module: active device address register.
// Assumes apply is raised only when a data transmit completes.
module usb_reply_addr (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       apply,
    input  logic [6:0] new_addr,
    output logic [6:0] dev_addr
);
    // Adopt the pending address on a completed data transmit
    always_ff @(posedge clk) begin
        if (!rst_n)     dev_addr <= 7'd0;
        else if (apply) dev_addr <= new_addr;
    end
endmodule

// File: rtl/usb_reply_ctrl.sv
// Module: USB device packet response controller (top).
// Captures each ended packet, decodes it in one cycle, and holds a reply
// request until the transmitter reports completion. Packets arriving while a
// reply is in flight are assumed not to occur (bus turnaround rules).
module usb_reply_ctrl
    import usb_reply_pkg::*;
#(
    parameter int LEN_W   = 5,
    parameter bit EN_OUT1 = 1'b1,
    parameter bit EN_EP3  = 1'b1,
    localparam int NUM_EP = EN_EP3 ? 3 : 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pkt_valid,
    input  logic [LEN_W-1:0]    pkt_len,
    input  logic [7:0]          pkt_pid,
    input  logic [7:0]          pkt_b1,
    input  logic [7:0]          pkt_b2,
    input  logic [NUM_EP*8-1:0] ep_status,
    input  logic                rx_done,
    input  logic [6:0]          new_addr,
    input  logic                tx_done,
    output logic                tx_req,
    output logic                tx_data,
    output logic [7:0]          tx_pid,
    output logic [EP_W-1:0]     tx_ep,
    output logic                ep_nak_wr,
    output logic [LEN_W-1:0]    rx_len,
    output logic [7:0]          rx_tok,
    output logic                rx_half,
    output logic [6:0]          dev_addr
);
    ctl_state_t       state;
    logic [7:0]       cap_pid, cap_b1, cap_b2, cur_tok;
    logic [LEN_W-1:0] cap_len;
    decision_t        dec;
    logic             store, addr_apply;

    usb_reply_decode #(.LEN_W(LEN_W), .EN_OUT1(EN_OUT1), .EN_EP3(EN_EP3)) u_dec (
        .pid(cap_pid), .len(cap_len), .b1(cap_b1), .b2(cap_b2),
        .cur_tok(cur_tok), .rx_len(rx_len), .dev_addr(dev_addr),
        .ep_status(ep_status), .dec(dec)
    );

    assign store      = (state == ST_DECODE) && dec.store;
    assign tx_req     = (state == ST_REPLY_REQ) || (state == ST_WAIT_TX_DONE);
    assign addr_apply = tx_req && tx_done && tx_data;

    usb_reply_rxbuf #(.LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .store(store), .len_in(cap_len),
        .tok_in(cur_tok), .consume(rx_done),
        .rx_len(rx_len), .rx_tok(rx_tok), .rx_half(rx_half)
    );

    usb_reply_addr u_addr (
        .clk(clk), .rst_n(rst_n), .apply(addr_apply),
        .new_addr(new_addr), .dev_addr(dev_addr)
    );

    // Reply sequencer: capture, decode, request, wait for transmit end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cap_pid   <= 8'h00;
            cap_b1    <= 8'h00;
            cap_b2    <= 8'h00;
            cap_len   <= '0;
            cur_tok   <= TOK_NONE;
            tx_data   <= 1'b0;
            tx_pid    <= 8'h00;
            tx_ep     <= '0;
            ep_nak_wr <= 1'b0;
        end else begin
            ep_nak_wr <= 1'b0;
            unique case (state)
                ST_IDLE: if (pkt_valid) begin
                    cap_pid <= pkt_pid;
                    cap_b1  <= pkt_b1;
                    cap_b2  <= pkt_b2;
                    cap_len <= pkt_len;
                    state   <= ST_DECODE;
                end
                ST_DECODE: begin
                    if (dec.tok_wr) cur_tok <= dec.tok_val;
                    if (dec.act != ACT_NONE) begin
                        tx_data   <= (dec.act == ACT_DATA);
                        tx_pid    <= dec.pid;
                        tx_ep     <= dec.ep;
                        ep_nak_wr <= (dec.act == ACT_DATA);
                        state     <= ST_REPLY_REQ;
                    end else begin
                        state     <= ST_IDLE;
                    end
                end
                ST_REPLY_REQ:    state <= tx_done ? ST_IDLE : ST_WAIT_TX_DONE;
                ST_WAIT_TX_DONE: if (tx_done) state <= ST_IDLE;
                default:         state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_reply_chk.sv
// Module: protocol checker for the reply controller, bound to the top.
// Assumes pkt_valid pulses for a single cycle per packet.
module usb_reply_chk #(
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic             tx_done,
    input logic             tx_req,
    input logic             tx_data,
    input logic [7:0]       tx_pid,
    input logic             ep_nak_wr,
    input logic [LEN_W-1:0] rx_len,
    input logic             rx_half,
    input logic [6:0]       dev_addr
);
    // R12
    reply_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> $past(pkt_valid, 2));
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_done) |=> tx_req);
    // R9
    rearm_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_nak_wr |-> (tx_req && tx_data && $rose(tx_req)));
    // R11
    addr_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_addr) |-> $past(tx_req && tx_done && tx_data));
    // R6
    half_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_half) |-> (rx_len != '0 && $past(rx_len) == '0));
    // R8
    hs_pid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_data) |-> tx_pid[4]);
endmodule

bind usb_reply_ctrl usb_reply_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .tx_done(tx_done),
    .tx_req(tx_req), .tx_data(tx_data), .tx_pid(tx_pid), .ep_nak_wr(ep_nak_wr),
    .rx_len(rx_len), .rx_half(rx_half), .dev_addr(dev_addr)
);

// File: tb/sim_usb_reply_ctrl.sv
module sim_usb_reply_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pkt_valid = 1'b0, rx_done = 1'b0, tx_done = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic [7:0] pkt_pid = 8'h00, pkt_b1 = 8'h00, pkt_b2 = 8'h00;
    logic [7:0] ep_st [3];
    logic [23:0] ep_status;
    logic [6:0] new_addr = 7'd0;
    logic tx_req, tx_data, ep_nak_wr, rx_half;
    logic [7:0] tx_pid, rx_tok;
    logic [1:0] tx_ep;
    logic [LEN_W-1:0] rx_len;
    logic [6:0] dev_addr;

    int total = 0, bad = 0;
    logic [7:0] m_tok = 8'h00, m_rxtok = 8'h00;
    int m_rxlen = 0;
    logic m_half = 1'b0;
    logic [6:0] m_addr = 7'd0;

    assign ep_status = {ep_st[2], ep_st[1], ep_st[0]};
    always #(CLK_PERIOD/2) clk = ~clk;

    usb_reply_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .pkt_pid(pkt_pid), .pkt_b1(pkt_b1), .pkt_b2(pkt_b2), .ep_status(ep_status),
        .rx_done(rx_done), .new_addr(new_addr), .tx_done(tx_done),
        .tx_req(tx_req), .tx_data(tx_data), .tx_pid(tx_pid), .tx_ep(tx_ep),
        .ep_nak_wr(ep_nak_wr), .rx_len(rx_len), .rx_tok(rx_tok), .rx_half(rx_half),
        .dev_addr(dev_addr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic consume();
        @(negedge clk) rx_done = 1'b1;
        @(negedge clk) rx_done = 1'b0;
        m_rxlen = 0;
        chk(rx_len == '0, "R4 rx_done frees", int'(rx_len), 0);
    endtask

    // One packet: predict from the requirements, drive, check the reply and state
    task automatic xact(input logic [7:0] pid, input int len, input logic [7:0] b1, input logic [7:0] b2);
        int kind = 0, eep = 0;
        logic [7:0] epid = 8'h00, ntok = m_tok;
        bit do_store = 0;
        string tag = "R13";
        if (len >= 3) begin
            if (pid == 8'hC3 || pid == 8'h4B) begin
                tag = "R4";
                if (m_tok != 8'h00) begin
                    kind = 1;
                    if (m_rxlen != 0) epid = 8'h5A;
                    else if (len < 4) begin epid = 8'hD2; tag = "R5"; end
                    else begin epid = 8'hD2; do_store = 1; tag = "R6"; end
                end
            end else if (b1[6:0] != m_addr) begin
                ntok = 8'h00; tag = "R2";
            end else if (pid == 8'h69) begin
                eep = b1[7] ? (b2[0] ? 2 : 1) : 0;
                if (m_rxlen != 0) begin kind = 1; epid = 8'h5A; tag = "R7"; end
                else if (ep_st[eep][4]) begin kind = 1; epid = ep_st[eep]; tag = "R8"; end
                else begin kind = 2; tag = "R9"; end
            end else if (pid == 8'h2D) begin
                ntok = 8'h2D; tag = "R3";
            end else if (pid == 8'hE1) begin
                ntok = b1[7] ? 8'hFF : 8'hE1; tag = "R3";
            end else begin
                ntok = 8'h00; tag = "R2";
            end
        end
        @(negedge clk);
        pkt_valid = 1'b1; pkt_pid = pid; pkt_len = LEN_W'(len); pkt_b1 = b1; pkt_b2 = b2;
        @(negedge clk) pkt_valid = 1'b0;
        @(negedge clk);
        chk(tx_req == (kind != 0), {"R12 ", tag, " reply presence"}, int'(tx_req), int'(kind != 0));
        chk(ep_nak_wr == (kind == 2), {tag, " rearm pulse"}, int'(ep_nak_wr), int'(kind == 2));
        if (kind == 1) begin
            chk(tx_data == 1'b0, {tag, " handshake kind"}, int'(tx_data), 0);
            chk(tx_pid == epid, {tag, " handshake pid"}, int'(tx_pid), int'(epid));
        end else if (kind == 2) begin
            chk(tx_data == 1'b1, "R9 data kind", int'(tx_data), 1);
            chk(tx_ep == 2'(eep), "R10 endpoint select", int'(tx_ep), eep);
        end
        if (kind != 0) begin
            repeat ($urandom % 3) begin
                @(negedge clk);
                chk(tx_req == 1'b1, "R12 request held", int'(tx_req), 1);
                chk(ep_nak_wr == 1'b0, "R9 single pulse", int'(ep_nak_wr), 0);
            end
            @(negedge clk) tx_done = 1'b1;
            @(negedge clk) tx_done = 1'b0;
            chk(tx_req == 1'b0, "R12 request dropped", int'(tx_req), 0);
            if (kind == 2) begin
                m_addr = new_addr;
                ep_st[eep] = 8'h5A;
            end
            chk(dev_addr == m_addr, "R11 address apply", int'(dev_addr), int'(m_addr));
        end else begin
            @(negedge clk);
            chk(tx_req == 1'b0, {tag, " no reply"}, int'(tx_req), 0);
        end
        m_tok = ntok;
        if (do_store) begin
            m_rxlen = len; m_rxtok = m_tok; m_half = ~m_half;
            chk(rx_tok == m_rxtok, "R6 stored token", int'(rx_tok), int'(m_rxtok));
        end
        chk(int'(rx_len) == m_rxlen, {tag, " rx_len"}, int'(rx_len), m_rxlen);
        chk(rx_half == m_half, {tag, " rx_half"}, int'(rx_half), int'(m_half));
    endtask

    function automatic logic [7:0] rand_status();
        case ($urandom % 4)
            0: rand_status = 8'h5A;
            1: rand_status = 8'h1E;
            default: rand_status = 8'($urandom % 12);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        ep_st[0] = 8'h5A; ep_st[1] = 8'h5A; ep_st[2] = 8'h5A;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tx_req == 0 && ep_nak_wr == 0, "R1 reset outputs", int'(tx_req), 0);
        chk(rx_len == 0 && rx_half == 0, "R1 reset rx", int'(rx_len), 0);
        chk(dev_addr == 0, "R1 reset address", int'(dev_addr), 0);
        rst_n = 1'b1;
        // Directed corners
        xact(8'hC3, 8, 8'h00, 8'h00);      // R4 no token: ignored
        xact(8'h2D, 3, 8'h00, 8'h00);      // R3 setup recorded
        xact(8'hC3, 2, 8'h00, 8'h00);      // R13 short packet
        xact(8'hC3, 3, 8'h00, 8'h00);      // R5 zero-length ACK
        xact(8'h4B, 11, 8'h00, 8'h00);     // R6 store
        xact(8'h69, 3, 8'h00, 8'h00);      // R7 NAK while pending
        xact(8'hC3, 6, 8'h00, 8'h00);      // R4 NAK while pending
        consume();
        ep_st[0] = 8'h05; new_addr = 7'd9;
        xact(8'h69, 3, 8'h00, 8'h00);      // R9 data, R11 address applied
        xact(8'h69, 3, 8'h00, 8'h00);      // R2 old address now mismatches
        xact(8'hC3, 8, 8'h09, 8'h00);      // R2 token cleared: data ignored
        ep_st[2] = 8'h1E;
        xact(8'h69, 3, 8'h89, 8'h01);      // R8/R10 third endpoint stall
        ep_st[1] = 8'h04;
        xact(8'h69, 3, 8'h89, 8'h00);      // R10 endpoint 1 data
        xact(8'hE1, 3, 8'h89, 8'h00);      // R3 OUT to endpoint 1 marker
        xact(8'hC3, 5, 8'h00, 8'h00);      // R6 stores marker token
        consume();
        // Random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] pid, b1;
            int len;
            case ($urandom % 6)
                0: pid = 8'hC3; 1: pid = 8'h4B; 2: pid = 8'h69;
                3: pid = 8'h2D; 4: pid = 8'hE1; default: pid = 8'hD2;
            endcase
            len = 1 + ($urandom % 11);
            b1 = 8'($urandom);
            if ($urandom % 4 != 0) b1[6:0] = m_addr;
            for (int e = 0; e < 3; e++) if ($urandom % 3 == 0) ep_st[e] = rand_status();
            if ($urandom % 5 == 0) new_addr = 7'($urandom);
            if (m_rxlen != 0 && $urandom % 3 == 0) consume();
            xact(pid, len, b1, 8'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule